// File: doc/BRIEF.md
# I2C Bus Idle Watchdog with Stuck-SDA Recovery

This block sits beside an I2C controller or target and watches the two bus wires for silence. A counter running on the system clock measures how long it has been since either line last changed level. When that silence lasts for the configured timeout, the block looks at the data wire. If SDA rests high, the bus is reported free. If SDA is held low, the block assumes that a transfer was cut off without a proper stop and that some device on the bus is still waiting for clocks. It then pulses SCL through an open-drain pull-down, up to nine times, until that device lets go of SDA.

The timeout has a long setting for normal use and a short setting for quicker detection. Both are parameters counted in system-clock cycles. A disable input stops all watchdog activity. The bus inputs are resynchronized inside the block. Recovery pulses are made only by pulling SCL low and letting it go, never by driving it high.

Top module: `i2c_bus_watchdog`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `scl_pull`, `bus_free` and `recovering` are all 0.
- R2: With the watchdog enabled, `cfg_fast` = 0 and SDA high, `bus_free` rises once no edge has been seen on either line for LONG_CYC cycles. The input synchronizer and the counter register add a few extra cycles. It does not rise earlier.
- R3: With `cfg_fast` = 1, the same detection uses SHORT_CYC cycles instead of LONG_CYC.
- R4: While `cfg_off` = 1, `bus_free` and `recovering` are 0 from the next cycle on. No recovery pulse is issued, however long the bus stays quiet.
- R5: Any level change on SCL or SDA, seen outside recovery, restarts the inactivity count and clears `bus_free`.
- R6: If the timeout expires while SDA is low, `recovering` goes to 1. The pulses then follow, each a stretch of exactly HALF_CYC cycles with `scl_pull` = 1 followed by HALF_CYC cycles with `scl_pull` = 0.
- R7: `scl_pull` (1 = pull SCL low) is 1 only while `recovering` is 1.
- R8: At the end of each release stretch, SDA is sampled. If it is high, recovery stops at once and `bus_free` becomes 1. `bus_free` and `recovering` are never 1 together.
- R9: One recovery issues at most PULSES (default 9) pulses. After the last one, watching resumes with a fresh count. If SDA is still low, another full recovery follows after another timeout.
- R10: A change of `cfg_fast` or `cfg_off` restarts the inactivity count and clears `bus_free`.
- R11: Level changes on SCL and SDA during recovery, including those caused by the block's own pulses, do not restart the count or cut the pulse train short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Observed SCL wire level (asynchronous) |
| sda_in | input | 1 | Observed SDA wire level (asynchronous) |
| cfg_fast | input | 1 | 1 selects the short timeout |
| cfg_off | input | 1 | 1 disables the watchdog |
| scl_pull | output | 1 | 1 pulls SCL low through the open-drain driver |
| bus_free | output | 1 | Bus found idle with SDA high |
| recovering | output | 1 | Recovery pulse train in progress |

## Verification
The assertions assume that HALF_CYC is at least four cycles. Below that, the block's own SCL edges would still be crossing the synchronizer when recovery ends. They also assume that SDA is an external input whose level at expiry alone chooses between reporting the bus free and starting recovery. The stimulus models the wire as a wired-AND of the bench's SCL and the block's pull-down, and uses HALF_CYC = 5. Configuration is changed only between scenarios or while the watchdog is disabled, so each timeout window begins at a known cycle.

// File: rtl/i2cwd_pkg.sv
package i2cwd_pkg;

    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_FREE  = 2'd1,
        ST_PULL  = 2'd2,
        ST_REL   = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

    typedef struct packed {
        logic fast;
        logic off;
    } wd_cfg_t;

    function automatic int unsigned width_for(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    function automatic logic in_recovery(input wd_state_e st);
        return (st == ST_PULL) || (st == ST_REL);
    endfunction

endpackage

// File: rtl/i2cwd_sync.sv
module i2cwd_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '1;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '1;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cwd_idle_timer.sv
module i2cwd_idle_timer #(
    parameter int unsigned LONG_CYC  = 100,
    parameter int unsigned SHORT_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic fast,
    input  logic run,
    input  logic reload,
    output logic expire
);
    import i2cwd_pkg::*;

    localparam int unsigned CW = width_for(LONG_CYC);
    localparam logic [CW-1:0] LONG_M1  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_CYC - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last   = fast ? SHORT_M1 : LONG_M1;
    assign expire = run && !reload && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || reload || !run || expire) cnt <= '0;
        else                                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cwd_ctrl.sv
module i2cwd_ctrl #(
    parameter int unsigned HALF_CYC = 8,
    parameter int unsigned PULSES   = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  off,
    input  logic                  reload,
    input  logic                  expire,
    input  logic                  sda_hi,
    output i2cwd_pkg::wd_state_e  state
);
    import i2cwd_pkg::*;

    localparam int unsigned HW = width_for(HALF_CYC);
    localparam int unsigned PW = width_for(PULSES);
    localparam logic [HW-1:0] HALF_M1 = HW'(HALF_CYC - 1);
    localparam logic [PW-1:0] PULS_M1 = PW'(PULSES - 1);

    wd_state_e       st_q, st_d;
    logic [HW-1:0]   half_q, half_d;
    logic [PW-1:0]   pls_q, pls_d;
    logic            half_done;

    assign half_done = (half_q == HALF_M1);

    always_comb begin
        st_d   = st_q;
        half_d = half_q;
        pls_d  = pls_q;
        if (off) begin
            st_d = ST_WATCH;
        end else begin
            unique case (st_q)
                ST_WATCH: begin
                    half_d = '0;
                    pls_d  = '0;
                    if (expire) st_d = sda_hi ? ST_FREE : ST_PULL;
                end
                ST_FREE: begin
                    if (reload) st_d = ST_WATCH;
                end
                ST_PULL: begin
                    half_d = half_q + 1'b1;
                    if (half_done) begin
                        half_d = '0;
                        st_d   = ST_REL;
                    end
                end
                ST_REL: begin
                    half_d = half_q + 1'b1;
                    if (half_done) begin
                        half_d = '0;
                        if (sda_hi) begin
                            st_d = ST_FREE;
                        end else if (pls_q == PULS_M1) begin
                            st_d = ST_WATCH;
                        end else begin
                            pls_d = pls_q + 1'b1;
                            st_d  = ST_PULL;
                        end
                    end
                end
                default: st_d = ST_WATCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_WATCH;
            half_q <= '0;
            pls_q  <= '0;
        end else begin
            st_q   <= st_d;
            half_q <= half_d;
            pls_q  <= pls_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/i2c_bus_watchdog.sv
module i2c_bus_watchdog #(
    parameter int unsigned LONG_CYC    = 100_000_000,
    parameter int unsigned SHORT_CYC   = 5_000_000,
    parameter int unsigned HALF_CYC    = 250,
    parameter int unsigned PULSES      = 9,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic cfg_fast,
    input  logic cfg_off,
    output logic scl_pull,
    output logic bus_free,
    output logic recovering
);
    import i2cwd_pkg::*;

    line_pair_t raw_lines, sync_lines, prev_lines;
    wd_cfg_t    cfg_now, cfg_prev;
    wd_state_e  state;
    logic       line_edge, activity, cfg_chg, reload, expire, run;
    logic       sda_sync;

    assign raw_lines = '{scl: scl_in, sda: sda_in};
    assign cfg_now   = '{fast: cfg_fast, off: cfg_off};

    i2cwd_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  ($bits(line_pair_t))
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lines <= '{scl: 1'b1, sda: 1'b1};
            cfg_prev   <= '0;
        end else begin
            prev_lines <= sync_lines;
            cfg_prev   <= cfg_now;
        end
    end

    assign sda_sync  = sync_lines.sda;
    assign line_edge = (sync_lines != prev_lines);
    assign activity  = line_edge && !in_recovery(state);
    assign cfg_chg   = (cfg_now != cfg_prev);
    assign reload    = activity || cfg_chg;
    assign run       = (state == ST_WATCH) && !cfg_off;

    i2cwd_idle_timer #(
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .fast   (cfg_fast),
        .run    (run),
        .reload (reload),
        .expire (expire)
    );

    i2cwd_ctrl #(
        .HALF_CYC (HALF_CYC),
        .PULSES   (PULSES)
    ) ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .off    (cfg_off),
        .reload (reload),
        .expire (expire),
        .sda_hi (sda_sync),
        .state  (state)
    );

    assign scl_pull   = (state == ST_PULL);
    assign bus_free   = (state == ST_FREE);
    assign recovering = in_recovery(state);
endmodule

// File: rtl/i2cwd_checker.sv
module i2cwd_checker #(
    parameter int unsigned HALF_CYC = 8,
    parameter int unsigned PULSES   = 9
) (
    input logic clk,
    input logic rst,
    input logic cfg_off,
    input logic scl_pull,
    input logic bus_free,
    input logic recovering,
    input logic sda_level
);
    int unsigned run_len;
    int unsigned pulse_cnt;
    logic        pull_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len   <= 0;
            pulse_cnt <= 0;
            pull_q    <= 1'b0;
        end else begin
            pull_q  <= scl_pull;
            run_len <= scl_pull ? run_len + 1 : 0;
            if (!recovering)              pulse_cnt <= 0;
            else if (scl_pull && !pull_q) pulse_cnt <= pulse_cnt + 1;
        end
    end

    p_pull_in_recov_r7: assert property (@(posedge clk) disable iff (rst)
        scl_pull |-> recovering);

    p_free_excl_rec_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_free && recovering));

    p_off_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_off |=> (!bus_free && !recovering));

    p_low_len_r6: assert property (@(posedge clk) disable iff (rst)
        run_len <= HALF_CYC);

    p_pulse_limit_r9: assert property (@(posedge clk) disable iff (rst)
        pulse_cnt <= PULSES);

    p_free_needs_sda_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_free) |-> $past(sda_level));

    p_rec_needs_low_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(recovering) |-> !$past(sda_level));
endmodule

bind i2c_bus_watchdog i2cwd_checker #(
    .HALF_CYC (HALF_CYC),
    .PULSES   (PULSES)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_off    (cfg_off),
    .scl_pull   (scl_pull),
    .bus_free   (bus_free),
    .recovering (recovering),
    .sda_level  (sda_sync)
);

// File: tb/i2c_bus_watchdog_tb_top.sv
module i2c_bus_watchdog_tb_top;
    localparam int LONG  = 200;
    localparam int SHORT = 60;
    localparam int HALF  = 5;
    localparam int NPUL  = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_tb = 1'b1, sda_tb = 1'b1;
    logic cfg_fast = 1'b0, cfg_off = 1'b0;
    logic scl_pull, bus_free, recovering;
    logic scl_wire;

    int total = 0, bad = 0, cyc = 0;
    int pulses = 0, bad_len = 0, outside = 0, run = 0;
    logic mon_clear = 1'b0;
    logic pull_prev = 1'b0;

    always #4 clk = ~clk;
    assign scl_wire = scl_tb & ~scl_pull;

    i2c_bus_watchdog #(
        .LONG_CYC (LONG), .SHORT_CYC (SHORT), .HALF_CYC (HALF), .PULSES (NPUL), .SYNC_STAGES (2)
    ) dut_i (
        .clk (clk), .rst (rst), .scl_in (scl_wire), .sda_in (sda_tb),
        .cfg_fast (cfg_fast), .cfg_off (cfg_off),
        .scl_pull (scl_pull), .bus_free (bus_free), .recovering (recovering)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mon_clear) begin
            pulses <= 0; bad_len <= 0; run <= 0; outside <= 0;
        end else begin
            if (scl_pull && !recovering) outside <= outside + 1;
            if (scl_pull) begin
                run <= run + 1;
                if (!pull_prev) pulses <= pulses + 1;
            end else begin
                if (pull_prev && run != HALF) bad_len <= bad_len + 1;
                run <= 0;
            end
        end
        pull_prev <= scl_pull;
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            bad = bad + 1; total = total + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_mon();
        mon_clear = 1'b1; tick(1); mon_clear = 1'b0;
    endtask

    function automatic logic [1:0] expect_flags(input int gap, input int lim, input bit sda);
        if (gap <= lim - 8) return 2'b00;
        return sda ? 2'b01 : 2'b10;
    endfunction

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        tick(3);
        chk("R1 scl_pull in reset", int'(scl_pull), 0);
        chk("R1 bus_free in reset", int'(bus_free), 0);
        rst = 1'b0; tick(1);
        chk("R1 recovering after reset", int'(recovering), 0);
        chk("R1 bus_free after reset", int'(bus_free), 0);

        // R2: long timeout with SDA high
        scl_tb = 1'b0; tick(1); scl_tb = 1'b1;
        tick(LONG - 10);
        chk("R2 not free before timeout", int'(bus_free), 0);
        tick(20);
        chk("R2 free after timeout", int'(bus_free), 1);

        // R5: activity clears free
        sda_tb = 1'b0; tick(1); sda_tb = 1'b1; tick(6);
        chk("R5 activity clears free", int'(bus_free), 0);
        tick(LONG - 20);
        chk("R5 count restarted", int'(bus_free), 0);
        tick(30);
        chk("R5 free again", int'(bus_free), 1);

        // R3 and R10: fast setting, change reloads and clears
        cfg_fast = 1'b1; tick(2);
        chk("R10 cfg change clears free", int'(bus_free), 0);
        tick(SHORT - 12);
        chk("R3 not free before short timeout", int'(bus_free), 0);
        tick(20);
        chk("R3 free after short timeout", int'(bus_free), 1);
        scl_tb = 1'b0; tick(1); scl_tb = 1'b1;
        tick(SHORT / 2);
        cfg_fast = 1'b0;
        tick(SHORT);
        chk("R10 change back restarts long count", int'(bus_free), 0);
        tick(LONG - SHORT - 10);
        chk("R10 still counting long", int'(bus_free), 0);
        tick(20);
        chk("R10 free after long from change", int'(bus_free), 1);

        // R4: disable
        cfg_off = 1'b1; tick(1);
        chk("R4 off clears free", int'(bus_free), 0);
        sda_tb = 1'b0; clear_mon();
        tick(2 * LONG);
        chk("R4 no recovery while off", int'(recovering), 0);
        chk("R4 no pulses while off", pulses, 0);
        chk("R4 no free while off", int'(bus_free), 0);

        // R6, R11: recovery with SDA stuck low
        cfg_off = 1'b0; clear_mon();
        tick(LONG - 10);
        chk("R6 no recovery before timeout", int'(recovering), 0);
        tick(20);
        chk("R6 recovering after timeout", int'(recovering), 1);
        tick(2 * HALF * NPUL);
        chk("R6 pulse count", pulses, NPUL);
        chk("R6 pulse low length", bad_len, 0);
        chk("R11 own scl edges ignored, train done", int'(recovering), 0);

        // R9: repeated recovery after fresh timeout
        clear_mon();
        tick(LONG - 20);
        chk("R9 watching again, quiet", int'(recovering), 0);
        chk("R9 no pulses before new timeout", pulses, 0);
        tick(LONG);
        chk("R9 second train pulses", pulses, NPUL);
        chk("R9 ended", int'(recovering), 0);

        // R8: early stop when SDA releases
        clear_mon();
        begin
            int guard = 0;
            while (pulses < 3 && guard < 3 * LONG) begin tick(1); guard++; end
        end
        tick(1);
        sda_tb = 1'b1;
        tick(2 * HALF + 6);
        chk("R8 stopped early", int'(recovering), 0);
        chk("R8 free after early stop", int'(bus_free), 1);
        chk("R8 pulse count cut short", int'(pulses <= 4), 1);
        tick(50);
        chk("R8 free holds without activity", int'(bus_free), 1);
        chk("R7 pull only during recovery", outside, 0);

        // random mix
        for (int it = 0; it < 30; it++) begin
            bit f, s, longgap;
            int lim, gap;
            logic [1:0] e;
            f = 1'($urandom_range(0, 1));
            s = 1'($urandom_range(0, 1));
            longgap = 1'($urandom_range(0, 1));
            lim = f ? SHORT : LONG;
            gap = longgap ? lim + 10 + int'($urandom_range(0, 50)) : int'($urandom_range(5, lim - 8));
            cfg_off = 1'b1; cfg_fast = f; sda_tb = s;
            scl_tb = 1'b0; tick(1); scl_tb = 1'b1; tick(4);
            cfg_off = 1'b0;
            tick(gap);
            e = expect_flags(gap, lim, s);
            chk(s ? "R2 random free flag" : "R6 random free flag", int'(bus_free), int'(e[0]));
            chk(s ? "R5 random recovery flag" : "R6 random recovery flag", int'(recovering), int'(e[1]));
        end
        chk("R7 pull only during recovery (random)", outside, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule